// File: doc/BRIEF.md
# Packed Signed Lane Multiplier with Pair Summing

This block is a two-stage pipelined arithmetic unit for packed integer data. Each 64-bit operand word carries four signed 16-bit lanes. In every lane the unit multiplies the matching lanes of the two words into a 32-bit signed product. A two-bit operation code then picks the result. It can pack the low 16 bits of all four products, or the high 16 bits of all four products. It can also add neighbouring products in pairs, which gives two 32-bit sums.

An operation is presented with `in_valid` high, together with its code and both words. Exactly two clock cycles later the result appears with `out_valid` high. A new operation can be accepted on every cycle. The operation code is registered with the operands, so back-to-back operations with different codes do not interfere. Lane width and lane count are parameters; the defaults give the 4 x 16-bit arrangement.

Top module: `pmul_unit`

## Requirements
- R1: Lane i of each operand word occupies bits [16i+15:16i] and is a signed two's complement value; the product of lane i of `in_a` and lane i of `in_b` is a 32-bit signed value p_i.
- R2: With `in_op` = 0 (low halves), bits [16i+15:16i] of `out_data` equal bits [15:0] of p_i, for i = 0..3.
- R3: With `in_op` = 1 (high halves), bits [16i+15:16i] of `out_data` equal bits [31:16] of p_i, for i = 0..3.
- R4: With `in_op` = 2 (pair sums), `out_data[31:0]` = p0 + p1 and `out_data[63:32]` = p2 + p3, each modulo 2^32; when all four lanes of both words hold -32768, each sum wraps to 0x80000000.
- R5: With `in_op` = 3 (unused code), `out_data` is all zeros for that operation.
- R6: `out_valid` is high in exactly the cycles that come two clock edges after a cycle with `in_valid` high. Operations may arrive on consecutive cycles, and each result uses the operation code that was presented with its own operands.
- R7: While `out_valid` is low, `out_data` keeps the value of the most recent result.
- R8: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| in_op | input | 2 | Operation code: 0 low halves, 1 high halves, 2 pair sums, 3 zero |
| in_a | input | 64 | First packed operand word |
| in_b | input | 64 | Second packed operand word |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 64 | Packed result |

## Verification
The hardest case to reach is a fully loaded pipeline where the operation code changes on every cycle. A lagging or misaligned code register would then pair each product with the wrong selection, and this still looks correct when the same code is used several times in a row. The stimulus therefore streams operations back to back and rotates the code on each one. It runs a sweep over a small set of corner lane values (zero, ±1, ±2, the extremes, and mid-range values) with lane offsets that vary, inserts idle gaps now and then to check that the result is held, and adds a dedicated all-minimum word pair to force the sum to wrap.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
   typedef enum logic [1:0] {
      PM_LOW     = 2'd0,
      PM_HIGH    = 2'd1,
      PM_PAIRSUM = 2'd2,
      PM_NONE    = 2'd3
   } pm_op_e;
endpackage

// File: rtl/pmul_lane_mul.sv
// One lane: registered signed multiply, loaded only when enabled.
module pmul_lane_mul #(
   parameter int LANE_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic [LANE_W-1:0]        a,
   input  logic [LANE_W-1:0]        b,
   output logic signed [2*LANE_W-1:0] prod
);
   localparam int PW = 2 * LANE_W;

   logic signed [PW-1:0] prod_c;

   always_comb begin
      prod_c = PW'($signed(a)) * PW'($signed(b));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  prod <= '0;
      else if (en) prod <= prod_c;
   end
endmodule

// File: rtl/pmul_pack_sel.sv
// Combinational result formation from the registered lane products.
module pmul_pack_sel #(
   parameter int LANE_W = 16,
   parameter int LANES  = 4
) (
   input  pmul_pkg::pm_op_e              op,
   input  logic [LANES*2*LANE_W-1:0]     prods,
   output logic [LANES*LANE_W-1:0]       data
);
   import pmul_pkg::*;

   localparam int PW     = 2 * LANE_W;
   localparam int DATA_W = LANES * LANE_W;
   localparam int PAIRS  = LANES / 2;

   logic [DATA_W-1:0] lo_w, hi_w, sum_w;

   for (genvar gi = 0; gi < LANES; gi++) begin : g_half
      assign lo_w[gi*LANE_W +: LANE_W] = prods[gi*PW +: LANE_W];
      assign hi_w[gi*LANE_W +: LANE_W] = prods[gi*PW + LANE_W +: LANE_W];
   end

   for (genvar gp = 0; gp < PAIRS; gp++) begin : g_pair
      logic [PW-1:0] even_p, odd_p;
      assign even_p = prods[(2*gp)*PW +: PW];
      assign odd_p  = prods[(2*gp+1)*PW +: PW];
      assign sum_w[gp*PW +: PW] = even_p + odd_p;
   end

   always_comb begin
      unique case (op)
         PM_LOW:     data = lo_w;
         PM_HIGH:    data = hi_w;
         PM_PAIRSUM: data = sum_w;
         default:    data = '0;
      endcase
   end
endmodule

// File: rtl/pmul_unit.sv
// Two-stage packed multiplier: stage 1 lane products, stage 2 selection.
module pmul_unit #(
   parameter int LANE_W = 16,
   parameter int LANES  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [1:0]               in_op,
   input  logic [LANES*LANE_W-1:0]  in_a,
   input  logic [LANES*LANE_W-1:0]  in_b,
   output logic                     out_valid,
   output logic [LANES*LANE_W-1:0]  out_data
);
   import pmul_pkg::*;

   localparam int PW     = 2 * LANE_W;
   localparam int DATA_W = LANES * LANE_W;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("pmul_unit: LANES must be even and at least 2");
   end
   if (LANE_W < 2) begin : g_bad_width
      $error("pmul_unit: LANE_W must be at least 2");
   end

   // stage 1
   logic              s1_valid;
   pm_op_e            s1_op;
   logic [LANES*PW-1:0] s1_prods;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_op    <= PM_LOW;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) s1_op <= pm_op_e'(in_op);
      end
   end

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      logic signed [PW-1:0] p;
      pmul_lane_mul #(.LANE_W(LANE_W)) i_mul (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (in_valid),
         .a    (in_a[gl*LANE_W +: LANE_W]),
         .b    (in_b[gl*LANE_W +: LANE_W]),
         .prod (p)
      );
      assign s1_prods[gl*PW +: PW] = p;
   end

   // stage 2
   logic [DATA_W-1:0] sel_data;

   pmul_pack_sel #(.LANE_W(LANE_W), .LANES(LANES)) i_sel (
      .op   (s1_op),
      .prods(s1_prods),
      .data (sel_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) out_data <= sel_data;
      end
   end
endmodule

// File: rtl/pmul_unit_chk.sv
module pmul_unit_chk #(
   parameter int LANE_W = 16,
   parameter int LANES  = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic [1:0]               in_op,
   input logic [LANES*LANE_W-1:0]  in_a,
   input logic [LANES*LANE_W-1:0]  in_b,
   input logic                     out_valid,
   input logic [LANES*LANE_W-1:0]  out_data
);
   localparam int PW     = 2 * LANE_W;
   localparam int DATA_W = LANES * LANE_W;

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
   end

   function automatic logic [DATA_W-1:0] model(input logic [1:0] op,
                                                input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
      logic [DATA_W-1:0] r;
      logic [PW-1:0] p [LANES];
      r = '0;
      for (int i = 0; i < LANES; i++)
         p[i] = PW'($signed(a[i*LANE_W +: LANE_W])) * PW'($signed(b[i*LANE_W +: LANE_W]));
      for (int i = 0; i < LANES; i++) begin
         if (op == 2'd0) r[i*LANE_W +: LANE_W] = p[i][LANE_W-1:0];
         if (op == 2'd1) r[i*LANE_W +: LANE_W] = p[i][PW-1:LANE_W];
      end
      if (op == 2'd2)
         for (int j = 0; j < LANES/2; j++) r[j*PW +: PW] = p[2*j] + p[2*j+1];
      return r;
   endfunction

   p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      since_rst == 2'd2 |-> out_valid == $past(in_valid, 2));

   p_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd2 && $past(in_valid, 2) && $past(in_op, 2) == 2'd0)
      |-> out_data == model(2'd0, $past(in_a, 2), $past(in_b, 2)));

   p_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd2 && $past(in_valid, 2) && $past(in_op, 2) == 2'd1)
      |-> out_data == model(2'd1, $past(in_a, 2), $past(in_b, 2)));

   p_pairsum_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd2 && $past(in_valid, 2) && $past(in_op, 2) == 2'd2)
      |-> out_data == model(2'd2, $past(in_a, 2), $past(in_b, 2)));

   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd2 && $past(in_valid, 2) && $past(in_op, 2) == 2'd3)
      |-> out_data == '0);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));

   p_reset_r8: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_data == '0));
endmodule

bind pmul_unit pmul_unit_chk #(.LANE_W(LANE_W), .LANES(LANES)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_op    (in_op),
   .in_a     (in_a),
   .in_b     (in_b),
   .out_valid(out_valid),
   .out_data (out_data)
);

// File: tb/test_pmul_unit.sv
module test_pmul_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = 2'd0;
   logic [63:0] in_a = '0, in_b = '0;
   logic        out_valid;
   logic [63:0] out_data;

   int checks = 0, errors = 0;
   bit done = 0;

   // expected pipeline: index 0 = driven last negedge, 1 = two negedges ago
   bit          ev [2];
   logic [63:0] ed [2];
   string       er [2];
   logic [63:0] last_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmul_unit i_pmul_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_result(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
      longint p [4];
      logic [63:0] r;
      r = '0;
      for (int i = 0; i < 4; i++)
         p[i] = longint'($signed(a[16*i +: 16])) * longint'($signed(b[16*i +: 16]));
      case (op)
         2'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'(p[i] & 64'hFFFF);
         2'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'((p[i] >>> 16) & 64'hFFFF);
         2'd2: begin
            r[31:0]  = 32'((p[0] + p[1]) & 64'hFFFF_FFFF);
            r[63:32] = 32'((p[2] + p[3]) & 64'hFFFF_FFFF);
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string op_req(input logic [1:0] op);
      case (op)
         2'd0: return "R2/R1 low halves";
         2'd1: return "R3/R1 high halves";
         2'd2: return "R4 pair sums";
         default: return "R5 unused code";
      endcase
   endfunction

   // one cycle: called at negedge; checks output, then drives next inputs
   task automatic step(input bit v, input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
      chk(out_valid == ev[1], "R6 valid timing", 64'(out_valid), 64'(ev[1]));
      if (ev[1]) begin
         chk(out_data == ed[1], er[1], out_data, ed[1]);
         last_data = ed[1];
      end else begin
         chk(out_data == last_data, "R7 hold while idle", out_data, last_data);
      end
      ev[1] = ev[0]; ed[1] = ed[0]; er[1] = er[0];
      ev[0] = v; ed[0] = ref_result(op, a, b); er[0] = op_req(op);
      in_valid = v; in_op = op; in_a = a; in_b = b;
      @(negedge clk);
   endtask

   function automatic logic [15:0] corner(input int k);
      case (k % 9)
         0: return 16'sd0;
         1: return 16'sd1;
         2: return -16'sd1;
         3: return 16'sd2;
         4: return -16'sd2;
         5: return 16'sd32767;
         6: return 16'h8000;
         7: return 16'sd12345;
         default: return -16'sd12345;
      endcase
   endfunction

   initial begin
      ev[0] = 0; ev[1] = 0; ed[0] = '0; ed[1] = '0; er[0] = ""; er[1] = "";
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(out_valid == 1'b0, "R8 reset valid", 64'(out_valid), 64'd0);
      chk(out_data == '0, "R8 reset data", out_data, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 wrap: all lanes at the minimum value
      step(1'b1, 2'd2, {4{16'h8000}}, {4{16'h8000}});
      step(1'b0, 2'd0, '0, '0);
      step(1'b0, 2'd0, '0, '0);
      chk(last_data == 64'h8000_0000_8000_0000, "R4 wrap to 0x80000000", last_data, 64'h8000_0000_8000_0000);

      // sweep: back-to-back, rotating codes, occasional idle gaps
      for (int x = 0; x < 9; x++) begin
         for (int y = 0; y < 9; y++) begin
            for (int o = 0; o < 4; o++) begin
               logic [63:0] a, b;
               for (int i = 0; i < 4; i++) begin
                  a[16*i +: 16] = corner(x + i);
                  b[16*i +: 16] = corner(y + 2*i + o);
               end
               step(1'b1, 2'((o + x + y) % 4), a, b);
               if (((x + y + o) % 7) == 0)
                  step(1'b0, 2'd3, ~a, ~b);  // idle: must not disturb R7
            end
         end
      end
      step(1'b0, 2'd0, '0, '0);
      step(1'b0, 2'd0, '0, '0);
      step(1'b0, 2'd0, '0, '0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule